// File: doc/BRIEF.md
# Private Interrupt Winner Selector

This block looks at the state of a processor's private interrupts (32 by default) and picks the one that should be signalled next. An interrupt can be picked only if it is pending, enabled, not active, and its resolved group is globally enabled. Among those candidates, the smallest priority value wins. If two candidates have the same priority, the one with the smaller interrupt number wins. The result is registered, so the ID, priority and group of the winner appear one clock after the inputs that produced them.

The same block also computes, for each interrupt group, whether this processor may be chosen as the target of a one-of-N distributed interrupt of that group. The processor is not eligible while it is marked as being in low-power state. It is also not eligible for a group that is globally disabled, or for a group whose per-group opt-out bit is set. Register access and the handshake toward the CPU interface are handled by neighbouring blocks.

Each interrupt's group is a 2-bit code: 0 is group 0, 1 is secure group 1, 2 is non-secure group 1, and 3 is unassigned. The 3-bit per-group vectors (`grp_en`, `grp_dis`, `dist_elig`) use bit 0 for group 0, bit 1 for secure group 1 and bit 2 for non-secure group 1.

Top module: `hpsel_top`

## Requirements
- R1: Interrupt i is a candidate only when irq_pend[i]=1, irq_en[i]=1, irq_act[i]=0 and grp_en has the bit of its group set. Group code 3 is never a candidate.
- R2: Among the candidates, hp_prio and hp_id belong to the one with the numerically smallest priority. The priority of interrupt i is irq_prio[8i+7:8i].
- R3: When several candidates share the smallest priority, the one with the smallest ID is chosen.
- R4: With no candidate, hp_valid=0, hp_prio=0xFF, hp_id=0 and hp_grp=0.
- R5: dist_elig is all zeros while pe_sleep=1. With pe_sleep=0, dist_elig bit g is 0 whenever grp_en bit g is 0.
- R6: dist_elig bit g is 0 whenever grp_dis bit g is 1. Otherwise it is 1 when pe_sleep=0 and grp_en bit g is 1.
- R7: All outputs are registered and reflect the inputs sampled at the previous rising clock edge. Between edges they hold their value.
- R8: hp_grp equals the group code irq_grp[2i+1:2i] of the winning interrupt i.
- R9: While rst_n is low, the outputs hold the idle result of R4 and dist_elig=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pend | input | NUM_IRQ | Pending bit per interrupt |
| irq_en | input | NUM_IRQ | Enable bit per interrupt |
| irq_act | input | NUM_IRQ | Active bit per interrupt |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority per interrupt; lower value means more urgent |
| irq_grp | input | NUM_IRQ*2 | Resolved group code per interrupt |
| grp_en | input | 3 | Global enable per group |
| pe_sleep | input | 1 | Processor marked as being in low-power state |
| grp_dis | input | 3 | Per-group opt-out from one-of-N delivery |
| hp_valid | output | 1 | A winner exists |
| hp_id | output | ID_W | ID of the winner |
| hp_prio | output | PRIO_W | Priority of the winner, 0xFF when idle |
| hp_grp | output | 2 | Group code of the winner |
| dist_elig | output | 3 | One-of-N eligibility per group |

## Verification
Each disqualifier is tried alone on a single candidate that would otherwise win. This separates the four conditions of the candidate test from one another and from the idle encoding. Priority ladders placed at high and low IDs show that the value wins over position. Equal-priority sets show that position decides the tie. A real candidate at priority 0xFF shows that the valid flag differs from the idle result. Randomised states with priorities drawn from a narrow range produce many ties, and the winner is compared against a linear scan. Eligibility is swept over all combinations of low-power, enable and opt-out bits. A check taken between edges confirms the one-cycle latency.

// File: rtl/hpsel_pkg.sv
package hpsel_pkg;

  localparam int NGRP = 3;
  localparam int PRIO_MAXW = 16;

  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_NONE = 2'd3
  } grp_t;

  // Is the group of this interrupt switched on globally?
  function automatic logic grp_on(input logic [1:0] grp, input logic [NGRP-1:0] en);
    logic r;
    case (grp)
      GRP_G0:   r = en[0];
      GRP_G1S:  r = en[1];
      GRP_G1NS: r = en[2];
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // Candidate test for one interrupt.
  function automatic logic is_cand(input logic pend, input logic en, input logic act,
                                   input logic [1:0] grp, input logic [NGRP-1:0] gen);
    return pend & en & ~act & grp_on(grp, gen);
  endfunction

  // Left operand (lower IDs) wins on equal priority.
  function automatic logic left_wins(input logic lv, input logic rv,
                                     input logic [PRIO_MAXW-1:0] lp,
                                     input logic [PRIO_MAXW-1:0] rp);
    return lv & (~rv | (lp <= rp));
  endfunction

  // One-of-N eligibility for a single group.
  function automatic logic elig_one(input logic sleep, input logic gen, input logic dis);
    return ~sleep & gen & ~dis;
  endfunction

endpackage

// File: rtl/hpsel_qual.sv
module hpsel_qual
  import hpsel_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0]   pend,
  input  logic [NUM_IRQ-1:0]   en,
  input  logic [NUM_IRQ-1:0]   act,
  input  logic [2*NUM_IRQ-1:0] grp,
  input  logic [NGRP-1:0]      gen,
  output logic [NUM_IRQ-1:0]   cand
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_q
    assign cand[i] = is_cand(pend[i], en[i], act[i], grp[2*i +: 2], gen);
  end

endmodule

// File: rtl/hpsel_tree.sv
module hpsel_tree
  import hpsel_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0]        cand,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  input  logic [2*NUM_IRQ-1:0]      grp,
  output logic                      w_vld,
  output logic [ID_W-1:0]           w_id,
  output logic [PRIO_W-1:0]         w_prio,
  output logic [1:0]                w_grp
);

  localparam int LVL    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2 * LEAVES;

  // Heap-indexed node storage: node 1 is the root, leaves at LEAVES..NODES-1.
  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [ID_W-1:0]   ni [NODES];
  logic [1:0]        ng [NODES];

  assign nv[0] = 1'b0;
  assign np[0] = '1;
  assign ni[0] = '0;
  assign ng[0] = '0;

  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l < NUM_IRQ) begin : g_real
      assign nv[LEAVES+l] = cand[l];
      assign np[LEAVES+l] = prio[l*PRIO_W +: PRIO_W];
      assign ni[LEAVES+l] = ID_W'(l);
      assign ng[LEAVES+l] = grp[2*l +: 2];
    end else begin : g_pad
      assign nv[LEAVES+l] = 1'b0;
      assign np[LEAVES+l] = '1;
      assign ni[LEAVES+l] = '0;
      assign ng[LEAVES+l] = '0;
    end
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    logic take_l;
    assign take_l = left_wins(nv[2*n], nv[2*n+1],
                              PRIO_MAXW'(np[2*n]), PRIO_MAXW'(np[2*n+1]));
    assign nv[n] = nv[2*n] | nv[2*n+1];
    assign np[n] = take_l ? np[2*n] : np[2*n+1];
    assign ni[n] = take_l ? ni[2*n] : ni[2*n+1];
    assign ng[n] = take_l ? ng[2*n] : ng[2*n+1];
  end

  assign w_vld  = nv[1];
  assign w_id   = nv[1] ? ni[1] : '0;
  assign w_prio = nv[1] ? np[1] : '1;
  assign w_grp  = nv[1] ? ng[1] : '0;

endmodule

// File: rtl/hpsel_elig.sv
module hpsel_elig
  import hpsel_pkg::*;
(
  input  logic            sleep,
  input  logic [NGRP-1:0] gen,
  input  logic [NGRP-1:0] dis,
  output logic [NGRP-1:0] elig
);

  for (genvar g = 0; g < NGRP; g++) begin : g_e
    assign elig[g] = elig_one(sleep, gen[g], dis[g]);
  end

endmodule

// File: rtl/hpsel_top.sv
module hpsel_top
  import hpsel_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ-1:0]        irq_en,
  input  logic [NUM_IRQ-1:0]        irq_act,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [2*NUM_IRQ-1:0]      irq_grp,
  input  logic [2:0]                grp_en,
  input  logic                      pe_sleep,
  input  logic [2:0]                grp_dis,
  output logic                      hp_valid,
  output logic [ID_W-1:0]           hp_id,
  output logic [PRIO_W-1:0]         hp_prio,
  output logic [1:0]                hp_grp,
  output logic [2:0]                dist_elig
);

  // Named internal events, visible to the bound checker.
  logic [NUM_IRQ-1:0] cand_vec;
  logic               sel_vld;
  logic [ID_W-1:0]    sel_id;
  logic [PRIO_W-1:0]  sel_prio;
  logic [1:0]         sel_grp;
  logic [NGRP-1:0]    elig_nxt;

  hpsel_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
    .pend (irq_pend),
    .en   (irq_en),
    .act  (irq_act),
    .grp  (irq_grp),
    .gen  (grp_en),
    .cand (cand_vec)
  );

  hpsel_tree #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tree (
    .cand   (cand_vec),
    .prio   (irq_prio),
    .grp    (irq_grp),
    .w_vld  (sel_vld),
    .w_id   (sel_id),
    .w_prio (sel_prio),
    .w_grp  (sel_grp)
  );

  hpsel_elig u_elig (
    .sleep (pe_sleep),
    .gen   (grp_en),
    .dis   (grp_dis),
    .elig  (elig_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_valid  <= 1'b0;
      hp_id     <= '0;
      hp_prio   <= '1;
      hp_grp    <= '0;
      dist_elig <= '0;
    end else begin
      hp_valid  <= sel_vld;
      hp_id     <= sel_id;
      hp_prio   <= sel_prio;
      hp_grp    <= sel_grp;
      dist_elig <= elig_nxt;
    end
  end

endmodule

// File: rtl/hpsel_chk.sv
module hpsel_chk
  import hpsel_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_IRQ-1:0]        irq_pend,
  input logic [NUM_IRQ-1:0]        irq_en,
  input logic [NUM_IRQ-1:0]        irq_act,
  input logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input logic [2*NUM_IRQ-1:0]      irq_grp,
  input logic [2:0]                grp_en,
  input logic                      pe_sleep,
  input logic [2:0]                grp_dis,
  input logic                      hp_valid,
  input logic [ID_W-1:0]           hp_id,
  input logic [PRIO_W-1:0]         hp_prio,
  input logic [1:0]                hp_grp,
  input logic [2:0]                dist_elig
);

  logic                      started;
  logic [NUM_IRQ-1:0]        q_pend, q_en, q_act;
  logic [NUM_IRQ*PRIO_W-1:0] q_prio;
  logic [2*NUM_IRQ-1:0]      q_grp;
  logic [2:0]                q_gen, q_dis;
  logic                      q_sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      q_pend <= '0; q_en <= '0; q_act <= '0;
      q_prio <= '0; q_grp <= '0;
      q_gen <= '0; q_dis <= '0; q_sleep <= 1'b0;
    end else begin
      started <= 1'b1;
      q_pend <= irq_pend; q_en <= irq_en; q_act <= irq_act;
      q_prio <= irq_prio; q_grp <= irq_grp;
      q_gen <= grp_en; q_dis <= grp_dis; q_sleep <= pe_sleep;
    end
  end

  logic any_cand, lower_exists, tie_lower_id;
  always_comb begin
    any_cand = 1'b0;
    lower_exists = 1'b0;
    tie_lower_id = 1'b0;
    for (int j = 0; j < NUM_IRQ; j++) begin
      if (q_pend[j] && q_en[j] && !q_act[j] && grp_on(q_grp[2*j +: 2], q_gen)) begin
        any_cand = 1'b1;
        if (q_prio[j*PRIO_W +: PRIO_W] < hp_prio) lower_exists = 1'b1;
        if (q_prio[j*PRIO_W +: PRIO_W] == hp_prio && j < int'(hp_id)) tie_lower_id = 1'b1;
      end
    end
  end

  assert_winner_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    started && hp_valid |-> q_pend[hp_id] && q_en[hp_id] && !q_act[hp_id]
                            && grp_on(q_grp[2*hp_id +: 2], q_gen));

  assert_no_lower_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    started && hp_valid |-> !lower_exists);

  assert_tie_lowest_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    started && hp_valid |-> !tie_lower_id);

  assert_idle_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_valid |-> hp_prio == '1 && hp_id == '0 && hp_grp == 2'd0);

  assert_idle_only_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    started && !hp_valid |-> !any_cand);

  assert_sleep_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    started && q_sleep |-> dist_elig == 3'b000);

  assert_grp_off_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (dist_elig & ~q_gen) == 3'b000);

  assert_optout_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (dist_elig & q_dis) == 3'b000);

  assert_group_of_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    started && hp_valid |-> hp_grp == q_grp[2*hp_id +: 2]);

endmodule

bind hpsel_top hpsel_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en), .irq_act(irq_act),
  .irq_prio(irq_prio), .irq_grp(irq_grp), .grp_en(grp_en), .pe_sleep(pe_sleep),
  .grp_dis(grp_dis), .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio),
  .hp_grp(hp_grp), .dist_elig(dist_elig)
);

// File: tb/sim_hpsel_top.sv
`timescale 1ns/1ps
module sim_hpsel_top;

  localparam int N = 32;
  localparam int PW = 8;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0, en = '0, act = '0;
  logic [N*PW-1:0] prio = '0;
  logic [2*N-1:0] grp = '0;
  logic [2:0]    gen = '0, dis = '0;
  logic          sleep = 1'b0;
  logic          hv;
  logic [IW-1:0] hid;
  logic [PW-1:0] hpr;
  logic [1:0]    hg;
  logic [2:0]    elig;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hpsel_top #(.NUM_IRQ(N), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_pend(pend), .irq_en(en), .irq_act(act),
    .irq_prio(prio), .irq_grp(grp), .grp_en(gen), .pe_sleep(sleep), .grp_dis(dis),
    .hp_valid(hv), .hp_id(hid), .hp_prio(hpr), .hp_grp(hg), .dist_elig(elig)
  );

  task automatic chk(input string req, input string what, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  // Linear reference scan written from the requirements.
  task automatic ref_scan(output bit v, output int id, output int p, output int g);
    v = 0; id = 0; p = 255; g = 0;
    for (int i = 0; i < N; i++) begin
      int gi = grp[2*i +: 2];
      bit on = (gi < 3) && gen[gi];
      int pi = prio[i*PW +: PW];
      if (pend[i] && en[i] && !act[i] && on) begin
        if (!v || pi < p) begin v = 1; id = i; p = pi; g = gi; end
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_win(input string req);
    bit v; int id, p, g;
    ref_scan(v, id, p, g);
    chk(req, "valid", int'(hv), int'(v));
    chk(req, "id", int'(hid), id);
    chk(req, "prio", int'(hpr), p);
    chk(req, "grp", int'(hg), g);
  endtask

  task automatic clear_all();
    pend = '0; en = '0; act = '0; prio = '0; grp = '0; gen = 3'b111; dis = '0; sleep = 0;
  endtask

  task automatic set_irq(input int i, input int p, input int g);
    pend[i] = 1; en[i] = 1; act[i] = 0;
    prio[i*PW +: PW] = PW'(p); grp[2*i +: 2] = 2'(g);
  endtask

  task automatic t_reset();
    rst_n = 0; sleep = 0; gen = 3'b111; set_irq(3, 1, 0);
    @(negedge clk); @(negedge clk);
    chk("R9", "valid", int'(hv), 0);
    chk("R9", "prio", int'(hpr), 255);
    chk("R9", "id", int'(hid), 0);
    chk("R9", "elig", int'(elig), 0);
    rst_n = 1;
    clear_all();
    step();
  endtask

  task automatic t_disqualify();
    for (int k = 0; k < 5; k++) begin
      clear_all(); set_irq(9, 16, 2);
      case (k)
        0: pend[9] = 0;
        1: en[9] = 0;
        2: act[9] = 1;
        3: gen[2] = 0;
        default: grp[19:18] = 2'd3;
      endcase
      step();
      chk("R1", "valid", int'(hv), 0);
      chk("R4", "idle prio", int'(hpr), 255);
      chk("R4", "idle id", int'(hid), 0);
    end
    clear_all(); set_irq(9, 16, 2); step();
    chk("R1", "valid", int'(hv), 1);
    chk("R8", "grp", int'(hg), 2);
  endtask

  task automatic t_priority();
    clear_all();
    set_irq(2, 40, 0); set_irq(30, 5, 1); set_irq(17, 6, 2);
    step();
    chk("R2", "id", int'(hid), 30);
    chk("R2", "prio", int'(hpr), 5);
    chk("R8", "grp", int'(hg), 1);
    act[30] = 1; step();
    chk("R2", "id after active", int'(hid), 17);
  endtask

  task automatic t_tie();
    clear_all();
    set_irq(25, 8, 0); set_irq(11, 8, 2); set_irq(20, 8, 1);
    step();
    chk("R3", "id", int'(hid), 11);
    set_irq(0, 8, 0); step();
    chk("R3", "id", int'(hid), 0);
  endtask

  task automatic t_ff_candidate();
    clear_all(); set_irq(31, 255, 2); step();
    chk("R4", "valid with ff", int'(hv), 1);
    chk("R4", "id with ff", int'(hid), 31);
  endtask

  task automatic t_latency();
    clear_all(); set_irq(4, 3, 0); step();
    set_irq(1, 2, 0);
    #1;
    chk("R7", "held before edge", int'(hid), 4);
    step();
    chk("R7", "after edge", int'(hid), 1);
  endtask

  task automatic t_elig();
    for (int c = 0; c < 128; c++) begin
      clear_all();
      sleep = c[6]; gen = c[5:3]; dis = c[2:0];
      step();
      for (int g = 0; g < 3; g++) begin
        int e = (!sleep && gen[g] && !dis[g]) ? 1 : 0;
        chk(sleep ? "R5" : (dis[g] ? "R6" : "R5"), "elig bit", int'(elig[g]), e);
      end
    end
  endtask

  task automatic t_random();
    for (int it = 0; it < 300; it++) begin
      pend = $urandom; en = $urandom | $urandom; act = $urandom & $urandom;
      grp = {$urandom, $urandom};
      gen = 3'($urandom);
      for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'(($urandom % 4) * 17);
      step();
      expect_win("R2_R3");
    end
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_disqualify();
    t_priority();
    t_tie();
    t_ff_candidate();
    t_latency();
    t_elig();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule